// File: doc/BRIEF.md
# Serial-to-Parallel Pixel Expander

This block takes the byte stream from a microcontroller's SPI master and turns it into write cycles on a display controller's 16-bit parallel bus. The display needs only one address line, a register-select output. That line tells command writes apart from data writes. Every chip-select frame opens with an 8-bit header that picks what the rest of the frame means. The frame can carry plain 16-bit words. It can load one of two colour registers. It can also carry a 1-bit-per-pixel bitmap, in which every serial bit becomes one full pixel write.

A font glyph stored as one bit per pixel can therefore be shifted straight out of the SPI port. A one bit writes the foreground colour and a zero bit writes the background colour. A second pixel mode captures a 16-bit base word first. It then writes that word once for each further bit, with the word's lowest bit replaced by the bit just received. This serves displays that apply their own transparency compare on the written value.

The serial clock, data and select inputs are synchronised into the system clock domain, and serial data is sampled on the rising edge of the serial clock. Each write has one setup cycle with the data already on the bus, followed by a low strobe of a parameterised length.

Top module: `spi_pix_expander`

## Requirements
- R1: While reset is held and after it is released, `lcd_wr_n` is 1, and `lcd_data` and `lcd_rs` are 0. Both colour registers reset to 0.
- R2: The first 8 bits of each frame, taken most significant bit first, form a header, and only its three lowest bits act as the opcode. Opcode 0 is command words, 1 is data words, 2 loads the foreground colour, 3 loads the background colour, 4 selects expansion and 5 selects low-bit tracking. The upper five header bits are ignored.
- R3: Under opcode 0, every 16 following bits, most significant bit first, produce one write of that word with `lcd_rs` at 0.
- R4: Under opcode 1, every 16 following bits produce one write of that word with `lcd_rs` at 1.
- R5: Under opcodes 2 and 3, every 16 following bits load the selected colour register and produce no write. A later word in the same frame replaces an earlier one.
- R6: Under opcode 4, each following bit produces exactly one write with `lcd_rs` at 1. The data is the foreground colour for a 1 and the background colour for a 0.
- R7: Under opcode 5, the first 16 following bits are held as a base word and produce no write. Each later bit then writes the base word with bit 0 replaced by that bit, with `lcd_rs` at 1.
- R8: Raising `spi_cs_n` ends the frame and discards a partial word. The next frame starts again with a header.
- R9: During a write, `lcd_data` and `lcd_rs` are driven one cycle before `lcd_wr_n` falls. `lcd_wr_n` stays low for exactly LOW_CYC cycles, and data and select stay unchanged while it is low.
- R10: Opcodes 6 and 7 cause no write for the rest of the frame.
- R11: Colour registers keep their values across frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| lcd_data | output | 16 | Parallel write data to the display |
| lcd_wr_n | output | 1 | Active-low write strobe |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |

## Verification
The assertions assume the serial clock is slow compared with the system clock. Each half period must outlast the synchroniser, the decode register and the complete setup-and-strobe sequence, so that no new write request reaches the strobe unit while it is busy. They also assume chip select changes only while the serial clock is low. The stimulus meets this by holding every serial-clock half period for eight system clocks and by moving select and data only while the serial clock is low. It also leaves idle gaps between frames that are long enough for the synchronised select to settle.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

   localparam logic [2:0] OP_CMD    = 3'd0;
   localparam logic [2:0] OP_DATA   = 3'd1;
   localparam logic [2:0] OP_FG     = 3'd2;
   localparam logic [2:0] OP_BG     = 3'd3;
   localparam logic [2:0] OP_EXPAND = 3'd4;
   localparam logic [2:0] OP_TRACK  = 3'd5;

   typedef enum logic [2:0] {
      ST_HDR,
      ST_RAW,
      ST_LDFG,
      ST_LDBG,
      ST_EXP,
      ST_BASE,
      ST_TRACK,
      ST_SKIP
   } pxe_state_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_LOW
   } pxe_phase_t;

endpackage

// File: rtl/pxe_sync.sv
module pxe_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pxe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pxe_edge.sv
module pxe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic mosi_s,
   input  logic csn_s,
   output logic bit_stb,
   output logic bit_val,
   output logic cs_act
);

   logic sck_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         bit_stb <= 1'b0;
         bit_val <= 1'b0;
         cs_act  <= 1'b0;
      end else begin
         sck_d   <= sck_s;
         bit_stb <= sck_s & ~sck_d & ~csn_s;
         bit_val <= mosi_s;
         cs_act  <= ~csn_s;
      end
   end

endmodule

// File: rtl/pxe_ctrl.sv
module pxe_ctrl
   import pxe_pkg::*;
#(
   parameter int W        = 16,
   parameter int HDR_W    = 8,
   parameter bit TRACK_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_act,
   input  logic           bit_stb,
   input  logic           bit_val,
   output logic           req,
   output logic [W-1:0]   req_data,
   output logic           req_rs,
   output pxe_state_t     st,
   output logic [W-1:0]   fg,
   output logic [W-1:0]   bg,
   output logic [W-1:0]   base
);

   localparam int MAXB = (W > HDR_W) ? W : HDR_W;
   localparam int CW   = $clog2(MAXB);
   localparam logic [CW-1:0] HDR_LAST  = CW'(HDR_W - 1);
   localparam logic [CW-1:0] WORD_LAST = CW'(W - 1);

   logic [CW-1:0] cnt;
   logic [W-1:0]  sh;
   logic [W-1:0]  word_nxt;
   logic          raw_rs;
   logic          track_ok;
   pxe_state_t    hdr_st;

   generate
      if (TRACK_EN) begin : g_track
         assign track_ok = 1'b1;
      end else begin : g_notrack
         assign track_ok = 1'b0;
      end
   endgenerate

   assign word_nxt = {sh[W-2:0], bit_val};

   always_comb begin
      case (word_nxt[2:0])
         OP_CMD, OP_DATA: hdr_st = ST_RAW;
         OP_FG:           hdr_st = ST_LDFG;
         OP_BG:           hdr_st = ST_LDBG;
         OP_EXPAND:       hdr_st = ST_EXP;
         OP_TRACK:        hdr_st = track_ok ? ST_BASE : ST_SKIP;
         default:         hdr_st = ST_SKIP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_HDR;
         cnt      <= '0;
         sh       <= '0;
         raw_rs   <= 1'b0;
         req      <= 1'b0;
         req_data <= '0;
         req_rs   <= 1'b0;
         fg       <= '0;
         bg       <= '0;
         base     <= '0;
      end else begin
         req <= 1'b0;
         if (!cs_act) begin
            st  <= ST_HDR;
            cnt <= '0;
         end else if (bit_stb) begin
            sh <= word_nxt;
            case (st)
               ST_HDR: begin
                  if (cnt == HDR_LAST) begin
                     cnt    <= '0;
                     st     <= hdr_st;
                     raw_rs <= (word_nxt[2:0] == OP_DATA);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_RAW, ST_LDFG, ST_LDBG, ST_BASE: begin
                  if (cnt == WORD_LAST) begin
                     cnt <= '0;
                     if (st == ST_RAW) begin
                        req      <= 1'b1;
                        req_data <= word_nxt;
                        req_rs   <= raw_rs;
                     end else if (st == ST_LDFG) begin
                        fg <= word_nxt;
                     end else if (st == ST_LDBG) begin
                        bg <= word_nxt;
                     end else begin
                        base <= word_nxt;
                        st   <= ST_TRACK;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_EXP: begin
                  req      <= 1'b1;
                  req_data <= bit_val ? fg : bg;
                  req_rs   <= 1'b1;
               end
               ST_TRACK: begin
                  req      <= 1'b1;
                  req_data <= {base[W-1:1], bit_val};
                  req_rs   <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/pxe_strobe.sv
module pxe_strobe
   import pxe_pkg::*;
#(
   parameter int W       = 16,
   parameter int LOW_CYC = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   input  logic [W-1:0] req_data,
   input  logic         req_rs,
   output logic [W-1:0] lcd_data,
   output logic         lcd_rs,
   output logic         lcd_wr_n,
   output logic         busy
);

   localparam int LW = $clog2(LOW_CYC + 1);
   localparam logic [LW-1:0] LOW_LAST = LW'(LOW_CYC - 1);

   pxe_phase_t    ph;
   logic [LW-1:0] lcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         lcnt     <= '0;
         lcd_data <= '0;
         lcd_rs   <= 1'b0;
         lcd_wr_n <= 1'b1;
      end else begin
         case (ph)
            PH_IDLE: begin
               if (req) begin
                  lcd_data <= req_data;
                  lcd_rs   <= req_rs;
                  ph       <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               lcd_wr_n <= 1'b0;
               lcnt     <= '0;
               ph       <= PH_LOW;
            end
            PH_LOW: begin
               if (lcnt == LOW_LAST) begin
                  lcd_wr_n <= 1'b1;
                  ph       <= PH_IDLE;
               end else begin
                  lcnt <= lcnt + 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy = (ph != PH_IDLE);

endmodule

// File: rtl/spi_pix_expander.sv
module spi_pix_expander
   import pxe_pkg::*;
#(
   parameter int W           = 16,
   parameter int HDR_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LOW_CYC     = 1,
   parameter bit TRACK_EN    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         spi_sck,
   input  logic         spi_mosi,
   input  logic         spi_cs_n,
   output logic [W-1:0] lcd_data,
   output logic         lcd_wr_n,
   output logic         lcd_rs
);

   generate
      if (W < 4) begin : g_bad_w
         $error("spi_pix_expander: W must be at least 4");
      end
      if (HDR_W < 3) begin : g_bad_hdr
         $error("spi_pix_expander: HDR_W must hold a 3-bit opcode");
      end
      if (LOW_CYC < 1) begin : g_bad_low
         $error("spi_pix_expander: LOW_CYC must be at least 1");
      end
   endgenerate

   logic [2:0]   sync_q;
   logic         bit_stb, bit_val, cs_act;
   logic         wr_req, wr_rs, wr_busy;
   logic [W-1:0] wr_data, fg_col, bg_col, base_word;
   pxe_state_t   ctl_st;

   pxe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sck, spi_mosi}),
      .q     (sync_q)
   );

   pxe_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_s   (sync_q[1]),
      .mosi_s  (sync_q[0]),
      .csn_s   (sync_q[2]),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .cs_act  (cs_act)
   );

   pxe_ctrl #(.W(W), .HDR_W(HDR_W), .TRACK_EN(TRACK_EN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .bit_stb  (bit_stb),
      .bit_val  (bit_val),
      .req      (wr_req),
      .req_data (wr_data),
      .req_rs   (wr_rs),
      .st       (ctl_st),
      .fg       (fg_col),
      .bg       (bg_col),
      .base     (base_word)
   );

   pxe_strobe #(.W(W), .LOW_CYC(LOW_CYC)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (wr_req),
      .req_data (wr_data),
      .req_rs   (wr_rs),
      .lcd_data (lcd_data),
      .lcd_rs   (lcd_rs),
      .lcd_wr_n (lcd_wr_n),
      .busy     (wr_busy)
   );

endmodule

// File: rtl/pxe_checker.sv
module pxe_checker
   import pxe_pkg::*;
#(
   parameter int W       = 16,
   parameter int LOW_CYC = 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_n,
   input logic [W-1:0] data,
   input logic         rs,
   input logic         req,
   input logic [W-1:0] req_data,
   input logic         busy,
   input pxe_state_t   st,
   input logic [W-1:0] fg,
   input logic [W-1:0] bg,
   input logic [W-1:0] base
);

   logic [15:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n)      low_run <= '0;
      else if (!wr_n)  low_run <= low_run + 1'b1;
      else             low_run <= '0;
   end

   p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n)) |-> ($stable(data) && $stable(rs)));

   p_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> ($stable(data) && $stable(rs)));

   p_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (low_run == 16'(LOW_CYC)));

   p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> !busy);

   p_exp_colour_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && st == ST_EXP) |-> (req_data == fg || req_data == bg));

   p_track_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && st == ST_TRACK) |-> (req_data[W-1:1] == base[W-1:1]));

   p_no_write_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req && st == ST_HDR) |-> $past(st) != ST_HDR);

endmodule

bind spi_pix_expander pxe_checker #(.W(W), .LOW_CYC(LOW_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_n     (lcd_wr_n),
   .data     (lcd_data),
   .rs       (lcd_rs),
   .req      (wr_req),
   .req_data (wr_data),
   .busy     (wr_busy),
   .st       (ctl_st),
   .fg       (fg_col),
   .bg       (bg_col),
   .base     (base_word)
);

// File: tb/sim_spi_pix_expander.sv
module sim_spi_pix_expander;

   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0;
   logic        spi_mosi = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic [15:0] lcd_data;
   logic        lcd_wr_n;
   logic        lcd_rs;

   int checks = 0;
   int errors = 0;
   int nwrites = 0;
   bit done = 1'b0;

   logic [16:0] exp_q[$];
   string       exp_tag[$];
   logic [15:0] m_fg = 16'h0000;
   logic [15:0] m_bg = 16'h0000;

   always #5 clk = ~clk;

   spi_pix_expander u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (spi_sck),
      .spi_mosi (spi_mosi),
      .spi_cs_n (spi_cs_n),
      .lcd_data (lcd_data),
      .lcd_wr_n (lcd_wr_n),
      .lcd_rs   (lcd_rs)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic push(input logic rs, input logic [15:0] d, input string tag);
      exp_q.push_back({rs, d});
      exp_tag.push_back(tag);
   endtask

   // monitor: every falling write strobe is one produced item
   logic prev_wr = 1'b1;
   always @(negedge clk) begin
      if (rst_n && prev_wr && !lcd_wr_n) begin
         nwrites++;
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected write", {15'b0, lcd_rs, lcd_data}, 32'hFFFFFFFF);
         end else begin
            logic [16:0] e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            check({lcd_rs, lcd_data} == e, t, {15'b0, lcd_rs, lcd_data}, {15'b0, e});
         end
      end
      prev_wr = lcd_wr_n;
   end

   task automatic spi_bit(input logic b);
      @(negedge clk) spi_mosi = b;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
   endtask

   task automatic spi_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) spi_bit(v[i]);
   endtask

   task automatic begin_frame(input logic [7:0] hdr);
      @(negedge clk) spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_bits({24'b0, hdr}, 8);
   endtask

   task automatic end_frame();
      repeat (3 * HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (4 * HALF) @(negedge clk);
   endtask

   task automatic expand_bits(input logic [31:0] v, input int n, input string tag);
      for (int i = n - 1; i >= 0; i--) push(1'b1, v[i] ? m_fg : m_bg, tag);
      spi_bits(v, n);
   endtask

   initial begin
      int w0;
      repeat (10) @(negedge clk);
      check(lcd_wr_n == 1'b1, "R1 wr_n in reset", {31'b0, lcd_wr_n}, 32'd1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(lcd_wr_n == 1'b1, "R1 wr_n after reset", {31'b0, lcd_wr_n}, 32'd1);
      check(lcd_data == 16'h0, "R1 data after reset", {16'b0, lcd_data}, 32'd0);
      check(lcd_rs == 1'b0, "R1 rs after reset", {31'b0, lcd_rs}, 32'd0);

      // R3 command words
      begin_frame(8'h00);
      push(1'b0, 16'h002C, "R3 cmd word 0"); spi_bits(32'h002C, 16);
      push(1'b0, 16'hA5F0, "R3 cmd word 1"); spi_bits(32'hA5F0, 16);
      end_frame();

      // R4 data words
      begin_frame(8'h01);
      push(1'b1, 16'h1234, "R4 data word"); spi_bits(32'h1234, 16);
      push(1'b1, 16'hFFFF, "R4 data ones"); spi_bits(32'hFFFF, 16);
      end_frame();

      // R1 colours reset to zero, seen through expansion
      begin_frame(8'h04);
      expand_bits(32'b10, 2, "R1 reset colour expand");
      end_frame();

      // R5 colour loads produce no write
      w0 = nwrites;
      begin_frame(8'h02); spi_bits(32'h1111, 16); spi_bits(32'hF800, 16); end_frame();
      m_fg = 16'hF800;
      begin_frame(8'h03); spi_bits(32'h001F, 16); end_frame();
      m_bg = 16'h001F;
      check(nwrites == w0, "R5 colour load writes", nwrites, w0);

      // R6 font byte expansion, R11 colours persist across frames
      begin_frame(8'h04);
      expand_bits(32'b10110010, 8, "R6 R11 expand byte");
      end_frame();
      begin_frame(8'h04);
      expand_bits(32'b0111, 4, "R11 expand second frame");
      end_frame();

      // R2 upper header bits ignored
      begin_frame(8'hF4);
      expand_bits(32'b01, 2, "R2 header upper bits");
      end_frame();

      // R7 low-bit tracking
      w0 = nwrites;
      begin_frame(8'h05);
      spi_bits(32'h07E0, 16);
      repeat (20) @(negedge clk);
      check(nwrites == w0, "R7 base word no write", nwrites, w0);
      push(1'b1, 16'h07E1, "R7 track 1"); spi_bit(1'b1);
      push(1'b1, 16'h07E0, "R7 track 0"); spi_bit(1'b0);
      push(1'b1, 16'h07E1, "R7 track 1b"); spi_bit(1'b1);
      end_frame();
      begin_frame(8'h05);
      spi_bits(32'hFFFF, 16);
      push(1'b1, 16'hFFFE, "R7 track ones base"); spi_bit(1'b0);
      end_frame();

      // R8 aborted frame discards partial word, next frame decodes header
      w0 = nwrites;
      begin_frame(8'h01);
      spi_bits(32'h3FF, 10);
      end_frame();
      check(nwrites == w0, "R8 partial word dropped", nwrites, w0);
      begin_frame(8'h00);
      push(1'b0, 16'h5555, "R8 restart header"); spi_bits(32'h5555, 16);
      end_frame();

      // R10 reserved opcodes
      w0 = nwrites;
      begin_frame(8'h06); spi_bits(32'hABCDE, 20); end_frame();
      begin_frame(8'h07); spi_bits(32'h12345, 20); end_frame();
      check(nwrites == w0, "R10 reserved opcodes", nwrites, w0);

      // R5 second load replaced the first, R9 write behaviour checked by data on the bus
      begin_frame(8'h04);
      expand_bits(32'b1, 1, "R5 last load wins");
      end_frame();

      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R9 all writes seen", exp_q.size(), 0);
      check(lcd_wr_n == 1'b1, "R9 strobe idle high", {31'b0, lcd_wr_n}, 32'd1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule